// File: doc/BRIEF.md
# Comparator Output Conditioning and Change Interrupt

This block takes the one-bit result of an analog comparator and prepares it for software and for a timer. The raw bit arrives asynchronously. It is brought into the system clock domain, optionally inverted, and optionally held in a latch that updates only when the timer's post-prescaler clock falls. The result is shown as a read-only status bit. It can also be sent, without synchronization, to a pin through an output mux. That mux honours the pin's tristate control. The result can also be chosen as the timer's gate source in place of an external gate pin.

Changes are detected against a reference copy of the output. The copy is retaken on every read or write of the main control register. While the live output differs from the copy, a sticky change flag is set on every cycle. Software clears the flag by writing 0 to it, and can raise it by writing 1. An interrupt request leaves the block only when the flag and three enables (peripheral, peripheral group and global) are all set.

The timer clock is a level input sampled by the system clock. A falling edge is the first sampled cycle in which the level is low after it was high. The register port is a simple one-cycle read/write strobe interface with a combinational read mux.

Top module: `cmp_out_irq`

## Requirements
- R1: Bit 6 of the main control register (address 0) reads the conditioned comparator output. It follows a raw input change after two system clock edges. Writes to bit 6 have no effect.
- R2: Bit 4 of the main control register is the polarity bit. When it is 1, the comparator output is inverted on the status bit, on the pin path and in the change detector.
- R3: Bit 5 of the main control register enables the pin path. `pin_out` is `cmp_raw` XOR polarity, taken combinationally with no register, and is 0 when the path is disabled. `pin_oe` is 1 only when the path is enabled and `pin_tris` is 0.
- R4: While the conditioned output differs from the reference copy, every clock edge sets the change flag (bit 3 at address 2). Any read or write of address 0 recaptures the reference from the current output.
- R5: Writing address 2 loads bit 3 into the change flag, so a write of 0 clears it and a write of 1 sets it.
- R6: `irq` is 1 exactly when the change flag, the peripheral enable (bit 2 at address 3), the group enable (bit 6 at address 3) and the global enable (bit 7 at address 3) are all 1. The flag sets whatever the enables are.
- R7: A mismatch in a cycle where address 0 is accessed does not set the flag. The reference takes the new value instead.
- R8: With the sync bit set (bit 0 at address 1), the internal output is a latch. The latch loads the inverted-as-configured synchronized value at each detected falling edge of `tmr_clk_ps` and holds at all other times.
- R9: `gate_src` equals `gate_pin_in` when the gate-select bit (bit 1 at address 1) is 0, and equals the internal output (latched or live, per R8) when it is 1.
- R10: After reset, all register reads return 0, and `irq`, `pin_out` and `pin_oe` are 0. This holds for the reference, the flag, the latch, polarity, sync, gate select, pin enable and all three enables.
- R11: A mismatch set takes priority over a same-cycle write of 0 to the flag, so the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator result, asynchronous |
| tmr_clk_ps | input | 1 | Timer clock after its prescaler, sampled by clk |
| gate_pin_in | input | 1 | External timer gate pin level |
| pin_tris | input | 1 | Tristate control of the output pin (1 = input) |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_out | output | 1 | Unsynchronized comparator output for the pin |
| pin_oe | output | 1 | Pin output enable |
| gate_src | output | 1 | Selected timer gate source |
| irq | output | 1 | Change interrupt request |

## Verification
The results arrive at different times. A raw input change reaches the status bit and `gate_src` after two clock edges, and the change flag and `irq` one edge later. The pin outputs follow their inputs in the same cycle. Register writes, reference recaptures and sync-latch loads take effect at the edge that samples the strobe or the timer falling edge. The bench drives inputs a quarter period after each rising edge and compares every output on the falling edge against a behavioural model that it advances at each rising edge. Directed sequences place raw changes, register accesses and timer edges on chosen cycles: one where a change meets a control read (R7), one where a flag clear meets an active mismatch (R11), and a latch that holds across a raw change (R8).

// File: rtl/cmpo_pkg.sv
package cmpo_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG  = 2'd2;
  localparam logic [ADDR_W-1:0] A_ENAB  = 2'd3;

  localparam int B_STAT  = 6;
  localparam int B_POL   = 4;
  localparam int B_PINEN = 5;
  localparam int B_SYNC  = 0;
  localparam int B_GSEL  = 1;
  localparam int B_FLAG  = 3;
  localparam int B_IE    = 2;
  localparam int B_GRP   = 6;
  localparam int B_GLB   = 7;

  function automatic logic polarize(input logic v, input logic inv);
    return v ^ inv;
  endfunction

  function automatic logic pick_out(input logic sync_en, input logic held, input logic live);
    return sync_en ? held : live;
  endfunction

  function automatic logic irq_gate(input logic flag, input logic ie, input logic grp, input logic glb);
    return flag & ie & grp & glb;
  endfunction
endpackage

// File: rtl/cmpo_sync.sv
module cmpo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpo_tlatch.sv
module cmpo_tlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_clk,
  input  logic d,
  output logic fall,
  output logic q
);
  logic tprev;

  assign fall = tprev & ~tmr_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tprev <= 1'b0;
      q     <= 1'b0;
    end else begin
      tprev <= tmr_clk;
      if (fall) q <= d;
    end
  end
endmodule

// File: rtl/cmpo_change.sv
module cmpo_change (
  input  logic clk,
  input  logic rst_n,
  input  logic cout,
  input  logic ref_load,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic mismatch,
  output logic set_evt,
  output logic ref_q,
  output logic flag_q
);
  assign mismatch = cout ^ ref_q;
  assign set_evt  = mismatch & ~ref_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ref_load) ref_q <= cout;
      if (set_evt)      flag_q <= 1'b1;
      else if (flag_wr) flag_q <= flag_wdata;
    end
  end
endmodule

// File: rtl/cmpo_regs.sv
module cmpo_regs
  import cmpo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              cout,
  input  logic              flag_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pol_q,
  output logic              pin_en_q,
  output logic              sync_q,
  output logic              gsel_q,
  output logic              ie_q,
  output logic              grp_q,
  output logic              glb_q,
  output logic              ref_load,
  output logic              flag_wr,
  output logic              flag_wdata
);
  logic wr_ctrl, wr_ctrl2, wr_enab;

  assign ref_load   = (bus_rd | bus_wr) & (bus_addr == A_CTRL);
  assign wr_ctrl    = bus_wr & (bus_addr == A_CTRL);
  assign wr_ctrl2   = bus_wr & (bus_addr == A_CTRL2);
  assign wr_enab    = bus_wr & (bus_addr == A_ENAB);
  assign flag_wr    = bus_wr & (bus_addr == A_FLAG);
  assign flag_wdata = bus_wdata[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q    <= 1'b0;
      pin_en_q <= 1'b0;
      sync_q   <= 1'b0;
      gsel_q   <= 1'b0;
      ie_q     <= 1'b0;
      grp_q    <= 1'b0;
      glb_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        pol_q    <= bus_wdata[B_POL];
        pin_en_q <= bus_wdata[B_PINEN];
      end
      if (wr_ctrl2) begin
        sync_q <= bus_wdata[B_SYNC];
        gsel_q <= bus_wdata[B_GSEL];
      end
      if (wr_enab) begin
        ie_q  <= bus_wdata[B_IE];
        grp_q <= bus_wdata[B_GRP];
        glb_q <= bus_wdata[B_GLB];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_STAT]  = cout;
        bus_rdata[B_POL]   = pol_q;
        bus_rdata[B_PINEN] = pin_en_q;
      end
      A_CTRL2: begin
        bus_rdata[B_SYNC] = sync_q;
        bus_rdata[B_GSEL] = gsel_q;
      end
      A_FLAG: bus_rdata[B_FLAG] = flag_q;
      default: begin
        bus_rdata[B_IE]  = ie_q;
        bus_rdata[B_GRP] = grp_q;
        bus_rdata[B_GLB] = glb_q;
      end
    endcase
  end
endmodule

// File: rtl/cmp_out_irq.sv
module cmp_out_irq
  import cmpo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic              tmr_clk_ps,
  input  logic              gate_pin_in,
  input  logic              pin_tris,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              gate_src,
  output logic              irq
);
  logic synced, cin, cout, latch_q, tmr_fall;
  logic pol_q, pin_en_q, sync_q, gsel_q, ie_q, grp_q, glb_q;
  logic ref_load, flag_wr, flag_wdata;
  logic mismatch, set_evt, ref_q, flag_q;

  cmpo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(synced)
  );

  assign cin = polarize(synced, pol_q);

  cmpo_tlatch u_tlatch (
    .clk(clk), .rst_n(rst_n), .tmr_clk(tmr_clk_ps), .d(cin),
    .fall(tmr_fall), .q(latch_q)
  );

  assign cout = pick_out(sync_q, latch_q, cin);

  cmpo_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cout(cout), .flag_q(flag_q),
    .bus_rdata(bus_rdata), .pol_q(pol_q), .pin_en_q(pin_en_q),
    .sync_q(sync_q), .gsel_q(gsel_q), .ie_q(ie_q), .grp_q(grp_q),
    .glb_q(glb_q), .ref_load(ref_load), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata)
  );

  cmpo_change u_change (
    .clk(clk), .rst_n(rst_n), .cout(cout), .ref_load(ref_load),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .mismatch(mismatch),
    .set_evt(set_evt), .ref_q(ref_q), .flag_q(flag_q)
  );

  assign pin_out  = pin_en_q & polarize(cmp_raw, pol_q);
  assign pin_oe   = pin_en_q & ~pin_tris;
  assign gate_src = gsel_q ? cout : gate_pin_in;
  assign irq      = irq_gate(flag_q, ie_q, grp_q, glb_q);
endmodule

// File: rtl/cmp_out_irq_chk.sv
module cmp_out_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic mismatch,
  input logic ref_load,
  input logic set_evt,
  input logic flag_q,
  input logic flag_wr,
  input logic flag_wdata,
  input logic cout,
  input logic ref_q,
  input logic irq,
  input logic glb_q,
  input logic pin_oe,
  input logic pin_tris,
  input logic tmr_fall,
  input logic latch_q
);
  assert_mismatch_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !ref_load) |=> flag_q);

  assert_access_recaptures_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_load |=> (ref_q == $past(cout)));

  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && !set_evt) |=> !flag_q);

  assert_sw_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wdata) |=> flag_q);

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && glb_q));

  assert_tris_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_tris |-> !pin_oe);

  assert_latch_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_fall |=> $stable(latch_q));

  assert_access_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_load && mismatch && !flag_q && !flag_wr) |=> !flag_q);
endmodule

bind cmp_out_irq cmp_out_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .ref_load(ref_load),
  .set_evt(set_evt), .flag_q(flag_q), .flag_wr(flag_wr),
  .flag_wdata(flag_wdata), .cout(cout), .ref_q(ref_q), .irq(irq),
  .glb_q(glb_q), .pin_oe(pin_oe), .pin_tris(pin_tris),
  .tmr_fall(tmr_fall), .latch_q(latch_q)
);

// File: tb/cmp_out_irq_bench.sv
`timescale 1ns/1ps
module cmp_out_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0, tmr_clk_ps = 1'b0, gate_pin_in = 1'b0, pin_tris = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       pin_out, pin_oe, gate_src, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmp_out_irq u_cmp_out_irq (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .tmr_clk_ps(tmr_clk_ps),
    .gate_pin_in(gate_pin_in), .pin_tris(pin_tris), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .gate_src(gate_src), .irq(irq)
  );

  // Behavioural reference model
  bit pipe[$];
  bit m_pol, m_pin, m_sync, m_gsel, m_ie, m_grp, m_glb;
  bit m_ref, m_flag, m_latch, m_tprev;
  bit t_cin, t_cout, t_acc, t_mism;

  function automatic bit live_out();
    return pipe[0] ^ m_pol;
  endfunction

  function automatic bit model_out();
    return m_sync ? m_latch : live_out();
  endfunction

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    logic [7:0] v = 8'd0;
    case (a)
      2'd0: begin v[6] = model_out(); v[4] = m_pol; v[5] = m_pin; end
      2'd1: begin v[0] = m_sync; v[1] = m_gsel; end
      2'd2: v[3] = m_flag;
      default: begin v[2] = m_ie; v[6] = m_grp; v[7] = m_glb; end
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{1'b0, 1'b0};
      {m_pol, m_pin, m_sync, m_gsel, m_ie, m_grp, m_glb} = '0;
      {m_ref, m_flag, m_latch, m_tprev} = '0;
    end else begin
      t_cin  = live_out();
      t_cout = model_out();
      t_acc  = (bus_rd || bus_wr) && bus_addr == 2'd0;
      t_mism = (t_cout != m_ref);
      if (t_mism && !t_acc)               m_flag = 1'b1;
      else if (bus_wr && bus_addr == 2'd2) m_flag = bus_wdata[3];
      if (m_tprev && !tmr_clk_ps) m_latch = t_cin;
      m_tprev = tmr_clk_ps;
      if (t_acc) m_ref = t_cout;
      if (bus_wr) begin
        case (bus_addr)
          2'd0: begin m_pol = bus_wdata[4]; m_pin = bus_wdata[5]; end
          2'd1: begin m_sync = bus_wdata[0]; m_gsel = bus_wdata[1]; end
          2'd3: begin m_ie = bus_wdata[2]; m_grp = bus_wdata[6]; m_glb = bus_wdata[7]; end
          default: ;
        endcase
      end
      pipe.push_back(cmp_raw);
      void'(pipe.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (bus_addr)
        2'd0: chk("R1/R2 ctrl readback", bus_rdata, model_rd(2'd0));
        2'd1: chk("R8/R9 ctrl2 readback", bus_rdata, model_rd(2'd1));
        2'd2: chk("R4/R5 flag readback", bus_rdata, model_rd(2'd2));
        default: chk("R6 enable readback", bus_rdata, model_rd(2'd3));
      endcase
      chk("R6 irq", {7'd0, irq}, {7'd0, m_flag & m_ie & m_grp & m_glb});
      chk("R3 pin_out", {7'd0, pin_out}, {7'd0, m_pin & (cmp_raw ^ m_pol)});
      chk("R3 pin_oe", {7'd0, pin_oe}, {7'd0, m_pin & !pin_tris});
      chk("R9 gate_src", {7'd0, gate_src}, {7'd0, m_gsel ? model_out() : gate_pin_in});
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    tick();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a);
    tick();
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic look(input logic [1:0] a);
    tick();
    bus_addr = a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      look(a[1:0]);
      chk("R10 reset register", bus_rdata, 8'h00);
    end
    chk("R10 reset irq", {7'd0, irq}, 8'h00);
    chk("R10 reset pin_oe", {7'd0, pin_oe}, 8'h00);
    chk("R10 reset pin_out", {7'd0, pin_out}, 8'h00);

    bus_write(2'd3, 8'hC4);
    bus_write(2'd0, 8'h20);
    // R1: raw rises, status and flag follow
    tick(); cmp_raw = 1'b1;
    repeat (4) tick();
    look(2'd0);
    chk("R1 status after raw rise", bus_rdata, 8'h60);
    look(2'd2);
    chk("R4 flag set by mismatch", bus_rdata, 8'h08);
    chk("R6 irq all enables", {7'd0, irq}, 8'h01);
    chk("R3 pin_out live", {7'd0, pin_out}, 8'h01);
    chk("R3 pin_oe enabled", {7'd0, pin_oe}, 8'h01);
    // R11: clearing during mismatch leaves the flag set
    bus_write(2'd2, 8'h00);
    look(2'd2);
    chk("R11 set beats clear", bus_rdata, 8'h08);
    // R5: read recaptures, then clear works
    bus_read(2'd0);
    bus_write(2'd2, 8'h00);
    look(2'd2);
    chk("R5 clear by writing 0", bus_rdata, 8'h00);
    chk("R5 irq drops", {7'd0, irq}, 8'h00);
    // R2 polarity, R1 write to status ignored
    bus_write(2'd0, 8'h70);
    tick();
    look(2'd0);
    chk("R1/R2 inverted status, bit6 write ignored", bus_rdata, 8'h30);
    chk("R2 pin_out inverted", {7'd0, pin_out}, 8'h00);
    look(2'd2);
    chk("R4 polarity change seen as mismatch", bus_rdata, 8'h08);
    // R6 global enable off
    bus_write(2'd3, 8'h44);
    look(2'd2);
    chk("R6 flag sets without global enable", bus_rdata, 8'h08);
    chk("R6 irq off without global enable", {7'd0, irq}, 8'h00);
    bus_write(2'd3, 8'hC4);
    look(2'd2);
    chk("R6 irq back on", {7'd0, irq}, 8'h01);
    // R5 software set
    bus_read(2'd0);
    bus_write(2'd2, 8'h00);
    look(2'd2);
    chk("R5 flag cleared", bus_rdata, 8'h00);
    bus_write(2'd2, 8'h08);
    look(2'd2);
    chk("R5 software set", bus_rdata, 8'h08);
    bus_write(2'd2, 8'h00);
    // R7: output changes in the cycle of a control read
    tick(); bus_addr = 2'd0; cmp_raw = 1'b0;
    tick();
    tick(); bus_rd = 1'b1;
    tick(); bus_rd = 1'b0;
    look(2'd2);
    chk("R7 change hidden by same-cycle read", bus_rdata, 8'h00);
    // R8 sync latch
    tick(); tmr_clk_ps = 1'b1;
    tick(); tmr_clk_ps = 1'b0;
    tick();
    bus_write(2'd1, 8'h01);
    bus_read(2'd0);
    bus_write(2'd2, 8'h00);
    tick(); bus_addr = 2'd0; cmp_raw = 1'b1;
    repeat (4) tick();
    @(negedge clk);
    chk("R8 latch holds across raw change", bus_rdata, 8'h70);
    look(2'd2);
    chk("R8 no mismatch while held", bus_rdata, 8'h00);
    tick(); bus_addr = 2'd0; tmr_clk_ps = 1'b1;
    tick(); tmr_clk_ps = 1'b0;
    tick();
    @(negedge clk);
    chk("R8 latch loads on timer fall", bus_rdata, 8'h30);
    // R9 gate source
    bus_write(2'd1, 8'h03);
    tick(); gate_pin_in = 1'b1;
    @(negedge clk);
    chk("R9 gate from latched output", {7'd0, gate_src}, 8'h00);
    bus_write(2'd1, 8'h00);
    @(negedge clk);
    chk("R9 gate from pin", {7'd0, gate_src}, 8'h01);
    bus_write(2'd1, 8'h02);
    @(negedge clk);
    chk("R9 gate from live output", {7'd0, gate_src}, 8'h00);

    // Mixed random traffic, model-checked every cycle
    for (int n = 0; n < 3000; n++) begin
      tick();
      if ($urandom_range(0, 5) == 0) cmp_raw = ~cmp_raw;
      if ($urandom_range(0, 2) == 0) tmr_clk_ps = ~tmr_clk_ps;
      gate_pin_in = 1'($urandom_range(0, 1));
      pin_tris    = 1'($urandom_range(0, 1));
      bus_addr    = 2'($urandom_range(0, 3));
      bus_wdata   = 8'($urandom_range(0, 255));
      case ($urandom_range(0, 5))
        0: begin bus_rd = 1'b1; bus_wr = 1'b0; end
        1: begin bus_rd = 1'b0; bus_wr = 1'b1; end
        default: begin bus_rd = 1'b0; bus_wr = 1'b0; end
      endcase
    end
    tick(); bus_rd = 1'b0; bus_wr = 1'b0;
    repeat (2) tick();
    finish_run();
  end
endmodule